// File: doc/BRIEF.md
# In-band XON/XOFF flow controller

This block automates software (in-band) flow control for a serial port. It sits between a serial receiver, the receive FIFO and a serial transmitter. On the receive side it checks every arriving character against four programmed flow characters. A matched stop character pauses the local transmitter and a matched go character releases it. Flow characters are removed from the stream, and every other character is passed on to the receive FIFO. On the transmit side it watches the receive FIFO fill level. When the level reaches the halt threshold it asks the transmitter to send a stop character once. When the level later drains to the resume threshold or below, it asks for a go character once.

Two separate 2-bit fields select which character set is used. `rx_mode` controls matching on receive and `tx_mode` controls generation on transmit. A value of 1 selects set 2, a value of 2 selects set 1, and a value of 3 uses both sets as an ordered pair. Both thresholds count groups of eight FIFO words. All automatic action requires `sw_en`.

The receive input has no ready signal, because a serial receiver cannot stall. Each `rx_valid` beat is consumed in the cycle it is presented, and the FIFO write port is likewise a valid-only stream. The injection port is valid/ready. `inj_valid` and `inj_char` hold steady until `inj_ready` is seen. The transmitter must accept a pending injected character at its next character boundary, ahead of its own queued data.

Top module: `swflow_ctrl`

## Requirements
- R1: With `rx_mode`=1 and `sw_en`=1, a received `xoff2_char` sets `tx_pause` and a received `xon2_char` clears it, one cycle after the beat. The set-1 characters are treated as ordinary data.
- R2: With `rx_mode`=2 and `sw_en`=1, `xoff1_char` sets `tx_pause` and `xon1_char` clears it, one cycle after the beat. The set-2 characters are treated as ordinary data.
- R3: With `rx_mode`=3, `tx_pause` is set only when `xoff1_char` is immediately followed, as the next valid character, by `xoff2_char`. It is cleared only by `xon1_char` immediately followed by `xon2_char`. Any other character in between cancels the pending pair.
- R4: When `rx_mode`=0 or `sw_en`=0, no character changes `tx_pause`, raises a flag or is dropped. While `sw_en` is 0, `tx_pause` reads 0 from the cycle after.
- R5: `spc_flags` pulses for one cycle, one cycle after a beat whose character equals a compared flow character. The bit positions are: bit 0 for `xon1_char`, bit 1 for `xon2_char`, bit 2 for `xoff1_char` and bit 3 for `xoff2_char`. Set 1 is compared when `rx_mode`[1]=1 and set 2 when `rx_mode`[0]=1. Without a beat, the flags are 0.
- R6: A received character that matches no compared flow character appears on `fifo_wr_data` with `fifo_wr_valid` one cycle after the beat. A matched flow character is never forwarded.
- R7: With `sw_en`=1, `tx_mode`≠0 and no halt in force, `fifo_level` ≥ 8×`halt_lvl` requests a stop character exactly once, one cycle after the level is seen. The character is `xoff2_char` for mode 1, `xoff1_char` for mode 2, and `xoff1_char` then `xoff2_char` for mode 3.
- R8: After a halt, `fifo_level` ≤ 8×`resume_lvl` requests a go character exactly once, using the same mode mapping with the go characters.
- R9: While `inj_valid` is high and `inj_ready` is low, `inj_valid` and `inj_char` hold. A handshake either moves on to the second character of a pair or drops `inj_valid` in the next cycle.
- R10: With `tx_mode`=0 or `sw_en`=0, no character is injected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_en | input | 1 | Global enable for automatic flow control |
| rx_mode | input | 2 | Receive match set selection |
| tx_mode | input | 2 | Transmit generation set selection |
| xon1_char | input | 8 | Go character, set 1 |
| xon2_char | input | 8 | Go character, set 2 |
| xoff1_char | input | 8 | Stop character, set 1 |
| xoff2_char | input | 8 | Stop character, set 2 |
| halt_lvl | input | 4 | Halt threshold in groups of 8 words |
| resume_lvl | input | 4 | Resume threshold in groups of 8 words |
| rx_valid | input | 1 | Received character present |
| rx_data | input | 8 | Received character |
| fifo_wr_valid | output | 1 | Forwarded character write strobe |
| fifo_wr_data | output | 8 | Forwarded character |
| fifo_level | input | 8 | Receive FIFO fill level in words |
| tx_pause | output | 1 | Hold the local transmitter |
| inj_valid | output | 1 | Injected character request |
| inj_char | output | 8 | Character to inject |
| inj_ready | input | 1 | Transmitter takes the injected character |
| spc_flags | output | 4 | Flow character detect pulses |

## Verification
Every receive-side result (`tx_pause`, `spc_flags`, `fifo_wr_valid` and `fifo_wr_data`) is registered once. It is therefore due in the cycle after the edge that samples the `rx_valid` beat. The bench drives each beat on a falling edge and compares all four outputs on the following falling edge against a bench-side model. An injection request is due one cycle after the edge that first sees the threshold crossed. The bench changes `fifo_level` on a falling edge and checks `inj_valid` and `inj_char` one falling edge later. It checks again after holding `inj_ready` low for several cycles and after each single-cycle handshake.

// File: rtl/swflow_pkg.sv
package swflow_pkg;
  localparam int FLG_ON1  = 0;
  localparam int FLG_ON2  = 1;
  localparam int FLG_OFF1 = 2;
  localparam int FLG_OFF2 = 3;

  typedef enum logic [1:0] {
    INJ_IDLE  = 2'd0,
    INJ_FIRST = 2'd1,
    INJ_LAST  = 2'd2
  } inj_state_t;

  localparam logic [1:0] SEL_NONE = 2'b00;
  localparam logic [1:0] SEL_PAIR = 2'b11;
endpackage

// File: rtl/swflow_rx_match.sv
module swflow_rx_match
  import swflow_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_en,
  input  logic [1:0]        rx_mode,
  input  logic [CHAR_W-1:0] on1,
  input  logic [CHAR_W-1:0] on2,
  input  logic [CHAR_W-1:0] off1,
  input  logic [CHAR_W-1:0] off2,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  output logic              pause,
  output logic [3:0]        flags
);
  logic       use1, use2, pair;
  logic [3:0] hit;
  logic       go_evt, stop_evt;
  logic       pend_go, pend_stop;

  assign use1 = sw_en & rx_mode[1];
  assign use2 = sw_en & rx_mode[0];
  assign pair = sw_en & (rx_mode == SEL_PAIR);

  always_comb begin
    hit           = '0;
    hit[FLG_ON1]  = use1 & (in_data == on1);
    hit[FLG_ON2]  = use2 & (in_data == on2);
    hit[FLG_OFF1] = use1 & (in_data == off1);
    hit[FLG_OFF2] = use2 & (in_data == off2);
    if (pair) begin
      stop_evt = pend_stop & hit[FLG_OFF2];
      go_evt   = pend_go & hit[FLG_ON2];
    end else begin
      stop_evt = hit[FLG_OFF1] | hit[FLG_OFF2];
      go_evt   = hit[FLG_ON1] | hit[FLG_ON2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause     <= 1'b0;
      pend_go   <= 1'b0;
      pend_stop <= 1'b0;
      flags     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid & ~(|hit);
      flags     <= in_valid ? hit : 4'b0000;
      if (in_valid) begin
        out_data  <= in_data;
        pend_go   <= pair & hit[FLG_ON1];
        pend_stop <= pair & hit[FLG_OFF1];
      end
      if (!pair) begin
        pend_go   <= 1'b0;
        pend_stop <= 1'b0;
      end
      if (!sw_en)                   pause <= 1'b0;
      else if (in_valid && stop_evt) pause <= 1'b1;
      else if (in_valid && go_evt)   pause <= 1'b0;
    end
  end
endmodule

// File: rtl/swflow_tx_inject.sv
module swflow_tx_inject
  import swflow_pkg::*;
#(
  parameter int CHAR_W    = 8,
  parameter int LVL_W     = 8,
  parameter int THR_W     = 4,
  parameter int GRP_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_en,
  input  logic [1:0]        tx_mode,
  input  logic [CHAR_W-1:0] on1,
  input  logic [CHAR_W-1:0] on2,
  input  logic [CHAR_W-1:0] off1,
  input  logic [CHAR_W-1:0] off2,
  input  logic [THR_W-1:0]  halt_lvl,
  input  logic [THR_W-1:0]  resume_lvl,
  input  logic [LVL_W-1:0]  level,
  output logic              req_valid,
  output logic [CHAR_W-1:0] req_char,
  input  logic              req_ready
);
  localparam int SCALED_W = THR_W + GRP_SHIFT;

  logic [SCALED_W-1:0] halt_sc, res_sc;
  logic [LVL_W-1:0]    halt_words, res_words;
  logic                halted;
  logic                trig_stop, trig_go;
  inj_state_t          st;

  assign halt_sc    = {halt_lvl, {GRP_SHIFT{1'b0}}};
  assign res_sc     = {resume_lvl, {GRP_SHIFT{1'b0}}};
  assign halt_words = LVL_W'(halt_sc);
  assign res_words  = LVL_W'(res_sc);
  assign trig_stop  = sw_en && (tx_mode != SEL_NONE) && !halted && (level >= halt_words);
  assign trig_go    = sw_en && (tx_mode != SEL_NONE) && halted && (level <= res_words);
  assign req_valid  = (st != INJ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= INJ_IDLE;
      halted   <= 1'b0;
      req_char <= '0;
    end else if (!sw_en) begin
      st     <= INJ_IDLE;
      halted <= 1'b0;
    end else begin
      unique case (st)
        INJ_IDLE: begin
          if (trig_stop || trig_go) begin
            halted <= trig_stop;
            if (tx_mode == SEL_PAIR) begin
              st       <= INJ_FIRST;
              req_char <= trig_stop ? off1 : on1;
            end else begin
              st <= INJ_LAST;
              if (tx_mode[1]) req_char <= trig_stop ? off1 : on1;
              else            req_char <= trig_stop ? off2 : on2;
            end
          end
        end
        INJ_FIRST: if (req_ready) begin
          st       <= INJ_LAST;
          req_char <= halted ? off2 : on2;
        end
        INJ_LAST: if (req_ready) st <= INJ_IDLE;
        default: st <= INJ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swflow_ctrl.sv
module swflow_ctrl #(
  parameter int CHAR_W    = 8,
  parameter int LVL_W     = 8,
  parameter int THR_W     = 4,
  parameter int GRP_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_en,
  input  logic [1:0]        rx_mode,
  input  logic [1:0]        tx_mode,
  input  logic [CHAR_W-1:0] xon1_char,
  input  logic [CHAR_W-1:0] xon2_char,
  input  logic [CHAR_W-1:0] xoff1_char,
  input  logic [CHAR_W-1:0] xoff2_char,
  input  logic [THR_W-1:0]  halt_lvl,
  input  logic [THR_W-1:0]  resume_lvl,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              fifo_wr_valid,
  output logic [CHAR_W-1:0] fifo_wr_data,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              tx_pause,
  output logic              inj_valid,
  output logic [CHAR_W-1:0] inj_char,
  input  logic              inj_ready,
  output logic [3:0]        spc_flags
);
  swflow_rx_match #(.CHAR_W(CHAR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .rx_mode(rx_mode),
    .on1(xon1_char), .on2(xon2_char), .off1(xoff1_char), .off2(xoff2_char),
    .in_valid(rx_valid), .in_data(rx_data),
    .out_valid(fifo_wr_valid), .out_data(fifo_wr_data),
    .pause(tx_pause), .flags(spc_flags)
  );

  swflow_tx_inject #(.CHAR_W(CHAR_W), .LVL_W(LVL_W), .THR_W(THR_W), .GRP_SHIFT(GRP_SHIFT)) u_tx (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .tx_mode(tx_mode),
    .on1(xon1_char), .on2(xon2_char), .off1(xoff1_char), .off2(xoff2_char),
    .halt_lvl(halt_lvl), .resume_lvl(resume_lvl), .level(fifo_level),
    .req_valid(inj_valid), .req_char(inj_char), .req_ready(inj_ready)
  );
endmodule

// File: rtl/swflow_ctrl_chk.sv
module swflow_ctrl_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_en,
  input logic [1:0]        tx_mode,
  input logic              rx_valid,
  input logic              fifo_wr_valid,
  input logic              tx_pause,
  input logic              inj_valid,
  input logic [CHAR_W-1:0] inj_char,
  input logic              inj_ready,
  input logic [3:0]        spc_flags
);
  assert_pause_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> !tx_pause);
  assert_flags_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> (spc_flags == 4'b0000));
  assert_fwd_needs_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_valid |-> $past(rx_valid));
  assert_no_fwd_flow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_wr_valid && (spc_flags != 4'b0000)));
  assert_inj_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && !inj_ready && sw_en) |=> (inj_valid && $stable(inj_char)));
  assert_inj_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inj_valid) |-> ($past(sw_en) && ($past(tx_mode) != 2'b00)));
endmodule

bind swflow_ctrl swflow_ctrl_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .tx_mode(tx_mode),
  .rx_valid(rx_valid), .fifo_wr_valid(fifo_wr_valid), .tx_pause(tx_pause),
  .inj_valid(inj_valid), .inj_char(inj_char), .inj_ready(inj_ready),
  .spc_flags(spc_flags)
);

// File: tb/swflow_ctrl_test.sv
module swflow_ctrl_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       sw_en = 0;
  logic [1:0] rx_mode = 0, tx_mode = 0;
  logic [7:0] xon1_char = 8'h11, xon2_char = 8'h91, xoff1_char = 8'h13, xoff2_char = 8'h93;
  logic [3:0] halt_lvl = 4'd4, resume_lvl = 4'd1;
  logic       rx_valid = 0;
  logic [7:0] rx_data = 0;
  logic       fifo_wr_valid;
  logic [7:0] fifo_wr_data;
  logic [7:0] fifo_level = 0;
  logic       tx_pause, inj_valid, inj_ready = 0;
  logic [7:0] inj_char;
  logic [3:0] spc_flags;

  int total = 0, bad = 0;
  logic m_pause = 0, m_pgo = 0, m_pstop = 0;

  always #2.5 clk = ~clk;

  swflow_ctrl uut (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_flags(input logic [7:0] c);
    logic u1, u2;
    u1 = sw_en & rx_mode[1];
    u2 = sw_en & rx_mode[0];
    return {u2 && c == xoff2_char, u1 && c == xoff1_char, u2 && c == xon2_char, u1 && c == xon1_char};
  endfunction

  task automatic send_char(input logic [7:0] c, input string req);
    logic [3:0] f;
    logic pr, stop, go;
    f = exp_flags(c);
    pr = sw_en && rx_mode == 2'b11;
    if (pr) begin
      stop = m_pstop && f[3];
      go = m_pgo && f[1];
    end else begin
      stop = f[2] | f[3];
      go = f[0] | f[1];
    end
    if (!sw_en) m_pause = 0;
    else if (stop) m_pause = 1;
    else if (go) m_pause = 0;
    m_pgo = pr && f[0];
    m_pstop = pr && f[2];
    rx_valid = 1; rx_data = c;
    @(negedge clk);
    rx_valid = 0;
    chk(spc_flags == f, {req, " flags R5"}, spc_flags, f);
    chk(fifo_wr_valid == (f == 0), {req, " fwd R6"}, fifo_wr_valid, f == 0);
    if (f == 0) chk(fifo_wr_data == c, {req, " data R6"}, fifo_wr_data, c);
    chk(tx_pause == m_pause, {req, " pause"}, tx_pause, m_pause);
  endtask

  task automatic rand_batch(input logic [1:0] m, input logic en, input string req);
    rx_mode = m; sw_en = en;
    @(negedge clk);
    if (!en) m_pause = 0;
    m_pgo = 0; m_pstop = 0;
    for (int i = 0; i < 80; i++) begin
      int r;
      logic [7:0] c;
      r = $urandom % 7;
      case (r)
        0: c = xon1_char; 1: c = xon2_char; 2: c = xoff1_char; 3: c = xoff2_char;
        default: c = 8'($urandom);
      endcase
      send_char(c, req);
    end
  endtask

  task automatic set_level(input logic [7:0] l);
    fifo_level = l;
    @(negedge clk);
  endtask

  task automatic take;
    inj_ready = 1;
    @(negedge clk);
    inj_ready = 0;
  endtask

  task automatic expect_inj(input logic v, input logic [7:0] c, input string req);
    chk(inj_valid == v, {req, " inj_valid"}, inj_valid, v);
    if (v) chk(inj_char == c, {req, " inj_char"}, inj_char, c);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!tx_pause && !inj_valid && !fifo_wr_valid && spc_flags == 0, "reset R4", tx_pause, 0);
    rst_n = 1;
    @(negedge clk);

    // Directed receive corner cases
    sw_en = 1; rx_mode = 2'b01;
    send_char(xoff1_char, "R1 set1 ignored");
    send_char(xoff2_char, "R1 stop");
    send_char(xon2_char, "R1 go");
    rx_mode = 2'b10;
    send_char(xoff2_char, "R2 set2 ignored");
    send_char(xoff1_char, "R2 stop");
    send_char(xon1_char, "R2 go");
    rx_mode = 2'b11;
    send_char(xoff2_char, "R3 lone second");
    send_char(xoff1_char, "R3 first");
    send_char(8'h41, "R3 broken");
    send_char(xoff2_char, "R3 after break");
    send_char(xoff1_char, "R3 pair a");
    send_char(xoff2_char, "R3 pair b");
    send_char(xon1_char, "R3 go a");
    send_char(xon2_char, "R3 go b");
    rx_mode = 2'b01;
    send_char(xoff2_char, "R4 prep");
    sw_en = 0; m_pause = 0;
    @(negedge clk);
    chk(tx_pause == 0, "R4 disable clears", tx_pause, 0);

    rand_batch(2'b01, 1, "R1 rand");
    rand_batch(2'b10, 1, "R2 rand");
    rand_batch(2'b11, 1, "R3 rand");
    rand_batch(2'b00, 1, "R4 rand");
    rand_batch(2'b11, 0, "R4 off rand");

    // Transmit injection
    sw_en = 1; tx_mode = 2'b10; halt_lvl = 4; resume_lvl = 1;
    set_level(31);
    @(negedge clk);
    expect_inj(0, 0, "R7 below halt");
    set_level(32);
    expect_inj(1, xoff1_char, "R7 halt mode2");
    repeat (3) @(negedge clk);
    expect_inj(1, xoff1_char, "R9 hold");
    take();
    expect_inj(0, 0, "R9 drop");
    set_level(40);
    repeat (2) @(negedge clk);
    expect_inj(0, 0, "R7 once");
    set_level(9);
    @(negedge clk);
    expect_inj(0, 0, "R8 above resume");
    set_level(8);
    expect_inj(1, xon1_char, "R8 go mode2");
    take();
    expect_inj(0, 0, "R8 once");

    tx_mode = 2'b01;
    set_level(33);
    expect_inj(1, xoff2_char, "R7 halt mode1");
    take();
    set_level(2);
    expect_inj(1, xon2_char, "R8 go mode1");
    take();

    tx_mode = 2'b11;
    set_level(50);
    expect_inj(1, xoff1_char, "R7 pair first");
    @(negedge clk);
    take();
    expect_inj(1, xoff2_char, "R7 pair second");
    take();
    expect_inj(0, 0, "R9 pair done");
    set_level(0);
    expect_inj(1, xon1_char, "R8 pair first");
    take();
    expect_inj(1, xon2_char, "R8 pair second");
    take();
    expect_inj(0, 0, "R8 pair done");

    tx_mode = 2'b00;
    set_level(100);
    @(negedge clk);
    expect_inj(0, 0, "R10 mode off");
    tx_mode = 2'b10; sw_en = 0;
    repeat (2) @(negedge clk);
    expect_inj(0, 0, "R10 disabled");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule